// File: doc/BRIEF.md
# SDR SDRAM Command Controller

This block sits between a simple host port and a single-data-rate SDRAM with four banks of 16-bit words. After reset it runs the power-up sequence and programs the mode register. From then on it turns each host read or write into the commands the memory needs. It keeps one open row per bank. A hit goes straight to the column command. A miss closes the bank and opens the wanted row first. An access to a closed bank opens it.

The host raises `req_valid` with bank, row, column, write data, byte enables and an auto-precharge flag, and holds them until `req_ready` is high at a clock edge. Read data comes back on `rsp_valid`/`rsp_data`. A separate refresh scheduler raises `ref_req` and holds it until `ref_ack`.

All command spacing comes from clock-cycle parameters: row-to-column delay, precharge time, row cycle time, write recovery and mode-register delay. The CAS latency parameter may be 2 or 3. The burst length is fixed at one word.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While reset is held, the command pins carry NOP ({cs_n,ras_n,cas_n,we_n}=0111), `req_ready`, `sd_dq_oe` and `rsp_valid` are low, and `sd_dqm` is all ones.
- R2: The first four commands after reset are PRECHARGE with A10=1 (code 0010), AUTO REFRESH (0001), AUTO REFRESH, and MODE REGISTER SET (0000). The mode word has A6:A4 equal to the CAS latency, A9=1 (single-location write), all other bits zero, and bank 0. MODE REGISTER SET is only issued with every bank idle.
- R3: The first PRECHARGE comes at least INIT_CYC cycles after reset. The first REFRESH comes at least T_RP cycles after it, each following init command at least T_RC cycles after the previous REFRESH, and the first ACTIVE (0011) at least T_MRD cycles after MODE REGISTER SET.
- R4: An access to a bank that is open on another row issues PRECHARGE to that bank (A10=0), then ACTIVE at least T_RP cycles later, then the column command at least T_RCD cycles after ACTIVE. Column commands only address open banks.
- R5: Read data on `sd_dq_in` is captured CL cycles after the READ (0101) cycle and presented with `rsp_valid` CL+1 cycles after it.
- R6: In the WRITE (0100) cycle `sd_dq_oe` is high, `sd_dq_out` equals the request data, and `sd_dqm` equals the inverted byte enables (bit 1 masks bits 15:8).
- R7: For a read, `sd_dqm` equals the inverted byte enables in the cycle CL-2 cycles after the READ, so masked bytes are not driven by the memory.
- R8: A10 on READ/WRITE equals the request's auto-precharge flag. After such an access the bank counts as closed, and the next access to it issues ACTIVE without PRECHARGE.
- R9: PRECHARGE to a bank comes at least T_RDL (2) cycles after the last WRITE to it.
- R10: A WRITE comes at least CL+2 cycles after a READ, leaving at least one idle cycle on the data bus.
- R11: `ref_req` holds `req_ready` low. If any bank is open, PRECHARGE-all is issued first and REFRESH follows at least T_RP cycles later. `ref_ack` is high exactly in the REFRESH cycle, and REFRESH is only issued with all banks idle.
- R12: A hit on an open row issues neither ACTIVE nor PRECHARGE, and ACTIVE is never issued to an open bank.
- R13: Two ACTIVE commands to the same bank are at least T_RC cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted at this edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_ap | input | 1 | Auto-precharge after this access |
| req_bank | input | 2 | Bank number |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DQ_W | Write data |
| req_be | input | DQ_W/8 | Byte enables |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | DQ_W | Read data |
| ref_req | input | 1 | Refresh wanted |
| ref_ack | output | 1 | Refresh command issued |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | ROW_W | Multiplexed address |
| sd_dqm | output | DQ_W/8 | Byte masks |
| sd_dq_out | output | DQ_W | Data to memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | DQ_W | Data from memory |

## Verification
A stale open-row register or bank-valid bit shows up at the pins at the next access to that bank. It appears either as a column command to a closed bank, which returns wrong data within CL+1 cycles, or as a missing or extra PRECHARGE/ACTIVE pair. A miscounted timer appears as two commands too close together in the next gap it governs. A read mask on the wrong cycle shows up as a wrong byte in the very response it belongs to. A bus-level memory model in the bench checks every command gap and the open/closed state of each bank as the commands occur, and compares returned data with a shadow of the host writes.

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl #(
  parameter int ROW_W    = 12,
  parameter int COL_W    = 8,
  parameter int DQ_W     = 16,
  parameter int CL       = 2,
  parameter int INIT_CYC = 100,
  parameter int T_RCD    = 2,
  parameter int T_RP     = 2,
  parameter int T_RC     = 7,
  parameter int T_RDL    = 2,
  parameter int T_MRD    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_we,
  input  logic               req_ap,
  input  logic [1:0]         req_bank,
  input  logic [ROW_W-1:0]   req_row,
  input  logic [COL_W-1:0]   req_col,
  input  logic [DQ_W-1:0]    req_wdata,
  input  logic [DQ_W/8-1:0]  req_be,
  output logic               rsp_valid,
  output logic [DQ_W-1:0]    rsp_data,
  input  logic               ref_req,
  output logic               ref_ack,
  output logic               sd_cs_n,
  output logic               sd_ras_n,
  output logic               sd_cas_n,
  output logic               sd_we_n,
  output logic [1:0]         sd_ba,
  output logic [ROW_W-1:0]   sd_addr,
  output logic [DQ_W/8-1:0]  sd_dqm,
  output logic [DQ_W-1:0]    sd_dq_out,
  output logic               sd_dq_oe,
  input  logic [DQ_W-1:0]    sd_dq_in
);
  localparam int AW = ROW_W;
  localparam int BW = DQ_W / 8;
  localparam int TW = $clog2(INIT_CYC + T_RC + T_RP + T_RDL + CL + 8);
  localparam logic [AW-1:0] MODE_WORD = AW'(512 + CL * 16);
  localparam logic [AW-1:0] ALL_BANKS = AW'(1024);

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD  = 4'b0101,
                         C_WR  = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_MRS = 4'b0000;

  typedef enum logic [2:0] {S_PWR, S_IREF, S_IMRS, S_IDLE, S_ROW} st_t;

  st_t              st;
  logic [TW-1:0]    tmr, act_tmr;
  logic             init_ref2;
  logic [3:0]       cmd_q;
  logic [1:0]       ba_q;
  logic [AW-1:0]    a_q;
  logic             dq_oe_q;
  logic [DQ_W-1:0]  dq_out_q;
  logic [3:0]       row_vld;
  logic [ROW_W-1:0] open_row [4];
  logic [CL:0]      rd_pipe;
  logic             r_we, r_ap;
  logic [1:0]       r_bank;
  logic [ROW_W-1:0] r_row;
  logic [COL_W-1:0] r_col;
  logic [DQ_W-1:0]  r_wdata;
  logic [BW-1:0]    r_be;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba     = ba_q;
  assign sd_addr   = a_q;
  assign sd_dq_oe  = dq_oe_q;
  assign sd_dq_out = dq_out_q;
  assign sd_dqm    = (dq_oe_q || rd_pipe[CL-2]) ? ~r_be : '1;
  assign req_ready = (st == S_IDLE) && (tmr == '0) && !ref_req;

  wire hit = row_vld[r_bank] && (open_row[r_bank] == r_row);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_PWR;
      tmr <= TW'(INIT_CYC);
      act_tmr <= '0;
      init_ref2 <= 1'b0;
      cmd_q <= C_NOP;
      ba_q <= '0;
      a_q <= '0;
      dq_oe_q <= 1'b0;
      dq_out_q <= '0;
      row_vld <= '0;
      for (int i = 0; i < 4; i++) open_row[i] <= '0;
      rd_pipe <= '0;
      rsp_valid <= 1'b0;
      rsp_data <= '0;
      ref_ack <= 1'b0;
      r_we <= 1'b0; r_ap <= 1'b0; r_bank <= '0; r_row <= '0;
      r_col <= '0; r_wdata <= '0; r_be <= '0;
    end else begin
      cmd_q <= C_NOP;
      dq_oe_q <= 1'b0;
      ref_ack <= 1'b0;
      rd_pipe <= {rd_pipe[CL-1:0], 1'b0};
      rsp_valid <= rd_pipe[CL];
      if (rd_pipe[CL]) rsp_data <= sd_dq_in;
      if (act_tmr != '0) act_tmr <= act_tmr - 1'b1;
      if (tmr != '0) tmr <= tmr - 1'b1;
      else begin
        case (st)
          S_PWR: begin
            cmd_q <= C_PRE; a_q <= ALL_BANKS;
            tmr <= TW'(T_RP - 1); st <= S_IREF;
          end
          S_IREF: begin
            cmd_q <= C_REF;
            tmr <= TW'(T_RC - 1); act_tmr <= TW'(T_RC - 1);
            init_ref2 <= 1'b1;
            if (init_ref2) st <= S_IMRS;
          end
          S_IMRS: begin
            cmd_q <= C_MRS; ba_q <= '0; a_q <= MODE_WORD;
            tmr <= TW'(T_MRD - 1); st <= S_IDLE;
          end
          S_IDLE: begin
            if (ref_req) begin
              if (|row_vld) begin
                cmd_q <= C_PRE; a_q <= ALL_BANKS;
                row_vld <= '0; tmr <= TW'(T_RP - 1);
              end else if (act_tmr == '0) begin
                cmd_q <= C_REF; ref_ack <= 1'b1;
                tmr <= TW'(T_RC - 1); act_tmr <= TW'(T_RC - 1);
              end
            end else if (req_valid) begin
              r_we <= req_we; r_ap <= req_ap; r_bank <= req_bank;
              r_row <= req_row; r_col <= req_col;
              r_wdata <= req_wdata; r_be <= req_be;
              st <= S_ROW;
            end
          end
          S_ROW: begin
            ba_q <= r_bank;
            if (hit) begin
              cmd_q <= r_we ? C_WR : C_RD;
              a_q <= AW'(r_col);
              a_q[10] <= r_ap;
              if (r_we) begin
                dq_oe_q <= 1'b1; dq_out_q <= r_wdata;
              end else begin
                rd_pipe <= {rd_pipe[CL-1:0], 1'b1};
              end
              tmr <= (r_we ? TW'(T_RDL - 1) : TW'(CL + 1)) + (r_ap ? TW'(T_RP) : TW'(0));
              if (r_ap) row_vld[r_bank] <= 1'b0;
              st <= S_IDLE;
            end else if (row_vld[r_bank]) begin
              cmd_q <= C_PRE; a_q <= '0;
              row_vld[r_bank] <= 1'b0; tmr <= TW'(T_RP - 1);
            end else if (act_tmr == '0) begin
              cmd_q <= C_ACT; a_q <= r_row;
              row_vld[r_bank] <= 1'b1; open_row[r_bank] <= r_row;
              tmr <= TW'(T_RCD - 1); act_tmr <= TW'(T_RC - 1);
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_pre_after_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_PRE) |-> ($past(cmd_q) != C_WR));

  assert_wr_after_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_WR) |-> (rd_pipe == '0 && !rsp_valid));

  assert_idle_for_ref_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_MRS || cmd_q == C_REF) |-> (row_vld == '0));

  assert_ack_on_ref_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |-> (cmd_q == C_REF));

  assert_col_bank_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_RD || cmd_q == C_WR) |-> (row_vld[ba_q] == !a_q[10]));

  assert_act_marks_open_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_ACT) |-> (row_vld[ba_q] && open_row[ba_q] == a_q));
endmodule

// File: tb/sim_sdram_cmd_ctrl.sv
module sim_sdram_cmd_ctrl;
  localparam int ROW_W = 12, COL_W = 8, DQ_W = 16, CL = 3;
  localparam int INIT_CYC = 10, T_RCD = 2, T_RP = 3, T_RC = 6, T_RDL = 2, T_MRD = 2;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, req_ap = 1'b0, ref_req = 1'b0;
  logic [1:0] req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [DQ_W-1:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rsp_valid, ref_ack;
  logic [DQ_W-1:0] rsp_data;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0] sd_ba, sd_dqm;
  logic [ROW_W-1:0] sd_addr;
  logic [DQ_W-1:0] sd_dq_out;
  logic [DQ_W-1:0] sd_dq_in = 16'hDEAD;

  sdram_cmd_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .CL(CL), .INIT_CYC(INIT_CYC),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_RDL(T_RDL), .T_MRD(T_MRD)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_ap(req_ap), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ref_req(ref_req), .ref_ack(ref_ack),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  wire [3:0] cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  // bus-level memory model and protocol monitor
  logic [15:0] mem [64];
  logic [15:0] shadow [64];
  logic open_b [4];
  logic [ROW_W-1:0] orow [4];
  int last_act [4], last_pre [4], last_wr [4];
  int last_rd = -1000, last_mrs = -1000, rd_due = -1, act_count = 0, pre_count = 0;
  logic [15:0] rd_val = '0;
  logic [1:0] dqm_d1 = 2'b11, dqm_d2 = 2'b11;
  logic [3:0] init_cmd [4];
  int init_cyc [4];
  logic [ROW_W-1:0] init_a [4];
  int ncmd = 0, rst_rel = 0;

  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = '0; shadow[i] = '0; end
    for (int b = 0; b < 4; b++) begin
      open_b[b] = 1'b0; orow[b] = '0; last_act[b] = -1000; last_pre[b] = -1000; last_wr[b] = -1000;
    end
  end

  always @(negedge clk) begin
    int b, idx;
    bit any;
    if (cyc == rd_due)
      sd_dq_in = {dqm_d2[1] ? 8'hEE : rd_val[15:8], dqm_d2[0] ? 8'hEE : rd_val[7:0]};
    else
      sd_dq_in = 16'hDEAD;
    dqm_d2 = dqm_d1;
    dqm_d1 = sd_dqm;
    b = int'(sd_ba);
    any = open_b[0] | open_b[1] | open_b[2] | open_b[3];
    if (rst_n && cmd != C_NOP) begin
      if (ncmd < 4) begin init_cmd[ncmd] = cmd; init_cyc[ncmd] = cyc; init_a[ncmd] = sd_addr; end
      ncmd++;
      case (cmd)
        C_ACT: begin
          act_count++;
          chk(!open_b[b], "R12 ACTIVE to open bank", 32'(open_b[b]), 0);
          chk(cyc - last_pre[b] >= T_RP, "R4 PRECHARGE-to-ACTIVE gap", 32'(cyc - last_pre[b]), T_RP);
          chk(cyc - last_act[b] >= T_RC, "R13 ACTIVE-to-ACTIVE gap", 32'(cyc - last_act[b]), T_RC);
          chk(cyc - last_mrs >= T_MRD, "R3 MRS-to-ACTIVE gap", 32'(cyc - last_mrs), T_MRD);
          open_b[b] = 1'b1; orow[b] = sd_addr; last_act[b] = cyc;
        end
        C_RD, C_WR: begin
          chk(open_b[b], "R4 column command to closed bank", 32'(open_b[b]), 1);
          chk(cyc - last_act[b] >= T_RCD, "R4 ACTIVE-to-column gap", 32'(cyc - last_act[b]), T_RCD);
          idx = b * 16 + int'(orow[b][1:0]) * 4 + int'(sd_addr[1:0]);
          if (cmd == C_WR) begin
            chk(cyc - last_rd >= CL + 2, "R10 READ-to-WRITE gap", 32'(cyc - last_rd), CL + 2);
            if (!sd_dqm[1]) mem[idx][15:8] = sd_dq_out[15:8];
            if (!sd_dqm[0]) mem[idx][7:0] = sd_dq_out[7:0];
            last_wr[b] = cyc;
          end else begin
            rd_due = cyc + CL; rd_val = mem[idx]; last_rd = cyc;
          end
          if (sd_addr[10]) begin
            open_b[b] = 1'b0;
            last_pre[b] = cyc + ((cmd == C_WR) ? T_RDL : 1);
          end
        end
        C_PRE: begin
          pre_count++;
          for (int k = 0; k < 4; k++)
            if (sd_addr[10] || k == b) begin
              if (open_b[k])
                chk(cyc - last_wr[k] >= T_RDL, "R9 WRITE-to-PRECHARGE gap", 32'(cyc - last_wr[k]), T_RDL);
              open_b[k] = 1'b0; last_pre[k] = cyc;
            end
        end
        C_REF: begin
          chk(!any, "R11 REFRESH with open bank", 32'(any), 0);
          for (int k = 0; k < 4; k++)
            chk(cyc - last_pre[k] >= T_RP, "R11 PRECHARGE-to-REFRESH gap", 32'(cyc - last_pre[k]), T_RP);
        end
        C_MRS: begin
          chk(!any, "R2 MRS with open bank", 32'(any), 0);
          last_mrs = cyc;
        end
        default: chk(1'b0, "R4 unknown command", 32'(cmd), 32'(C_NOP));
      endcase
    end
  end

  function automatic logic [15:0] pat(int b, int r, int c);
    return 16'(((b * 16 + r * 4 + c) * 2909) ^ 23130);
  endfunction

  task automatic issue(input bit we, input int b, input int r, input int c,
                       input logic [15:0] d, input logic [1:0] be, input bit ap);
    req_valid = 1'b1; req_we = we; req_bank = 2'(b); req_row = ROW_W'(r);
    req_col = COL_W'(c); req_wdata = d; req_be = be; req_ap = ap;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input int b, input int r, input int c,
                          input logic [15:0] d, input logic [1:0] be, input bit ap);
    int idx;
    idx = b * 16 + r * 4 + c;
    if (be[1]) shadow[idx][15:8] = d[15:8];
    if (be[0]) shadow[idx][7:0] = d[7:0];
    issue(1'b1, b, r, c, d, be, ap);
    while (cmd != C_WR) @(negedge clk);
    chk(sd_dqm == ~be, "R6 write mask", 32'(sd_dqm), 32'(~be));
    chk(sd_dq_oe && sd_dq_out == d, "R6 write data", 32'(sd_dq_out), 32'(d));
    chk(sd_addr[10] == ap, "R8 write A10", 32'(sd_addr[10]), 32'(ap));
  endtask

  task automatic do_read(input int b, input int r, input int c, input logic [1:0] be, input bit ap);
    int t;
    logic [15:0] e;
    e = shadow[b * 16 + r * 4 + c];
    if (!be[1]) e[15:8] = 8'hEE;
    if (!be[0]) e[7:0] = 8'hEE;
    issue(1'b0, b, r, c, 16'h0, be, ap);
    while (cmd != C_RD) @(negedge clk);
    t = cyc;
    chk(sd_addr[10] == ap, "R8 read A10", 32'(sd_addr[10]), 32'(ap));
    repeat (CL - 2) @(negedge clk);
    chk(sd_dqm == ~be, "R7 read mask latency", 32'(sd_dqm), 32'(~be));
    while (!rsp_valid) @(negedge clk);
    chk(cyc - t == CL + 1, "R5 read response latency", 32'(cyc - t), CL + 1);
    chk(rsp_data == e, "R5 R7 read data", 32'(rsp_data), 32'(e));
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int a0, p0;
    repeat (3) @(negedge clk);
    chk(cmd == C_NOP, "R1 reset command", 32'(cmd), 32'(C_NOP));
    chk(!req_ready && !sd_dq_oe && !rsp_valid, "R1 reset outputs", 32'({req_ready, sd_dq_oe, rsp_valid}), 0);
    chk(sd_dqm == 2'b11, "R1 reset mask", 32'(sd_dqm), 3);
    rst_n = 1'b1;
    rst_rel = cyc;
    while (!req_ready) @(negedge clk);
    chk(ncmd == 4, "R2 init command count", 32'(ncmd), 4);
    chk(init_cmd[0] == C_PRE && init_a[0][10], "R2 first command PRECHARGE all", 32'(init_cmd[0]), 32'(C_PRE));
    chk(init_cmd[1] == C_REF && init_cmd[2] == C_REF, "R2 two refreshes",
        32'({init_cmd[1], init_cmd[2]}), 32'({C_REF, C_REF}));
    chk(init_cmd[3] == C_MRS, "R2 mode register set", 32'(init_cmd[3]), 32'(C_MRS));
    chk(init_a[3] == 12'h230, "R2 mode word", 32'(init_a[3]), 32'h230);
    chk(init_cyc[0] - rst_rel >= INIT_CYC, "R3 power-up delay", 32'(init_cyc[0] - rst_rel), INIT_CYC);
    chk(init_cyc[1] - init_cyc[0] >= T_RP, "R3 PRE-to-REF", 32'(init_cyc[1] - init_cyc[0]), T_RP);
    chk(init_cyc[2] - init_cyc[1] >= T_RC, "R3 REF-to-REF", 32'(init_cyc[2] - init_cyc[1]), T_RC);
    chk(init_cyc[3] - init_cyc[2] >= T_RC, "R3 REF-to-MRS", 32'(init_cyc[3] - init_cyc[2]), T_RC);

    // sweep: full writes over every bank, 4 rows, 4 columns
    for (int r = 0; r < 4; r++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          do_write(b, r, c, pat(b, r, c), 2'b11, (c == 3 && r == 2));
    // partial writes
    for (int i = 0; i < 16; i++)
      do_write(i % 4, i / 4, (i + 1) % 4, ~pat(i, i, i), (i % 2 == 1) ? 2'b01 : 2'b10, 1'b0);
    // read back with cycling masks; reads and writes interleaved to stress turnaround
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++) begin
          do_read(b, r, c, (c % 3 == 0) ? 2'b11 : ((c % 3 == 1) ? 2'b01 : 2'b10), (c == 0 && b == 1));
          if (c == 2) do_write(b, r, 3, pat(r, c, b), 2'b11, 1'b0);
        end

    // R12: row hits across all four open banks
    for (int b = 0; b < 4; b++) do_read(b, 1, 1, 2'b11, 1'b0);
    a0 = act_count; p0 = pre_count;
    for (int b = 0; b < 4; b++) do_read(b, 1, 2, 2'b11, 1'b0);
    chk(act_count == a0 && pre_count == p0, "R12 hits issue no row commands",
        32'(act_count - a0 + pre_count - p0), 0);
    // R4: row miss
    do_write(2, 3, 1, 16'hC0DE, 2'b11, 1'b0);
    chk(act_count == a0 + 1 && pre_count == p0 + 1, "R4 miss issues PRE then ACT",
        32'({act_count - a0, pre_count - p0}), 32'h10001);
    // R8: auto-precharge closes the bank
    a0 = act_count; p0 = pre_count;
    do_read(3, 1, 1, 2'b11, 1'b1);
    do_read(3, 1, 2, 2'b11, 1'b0);
    chk(act_count == a0 + 1 && pre_count == p0, "R8 reopen after auto-precharge",
        32'({act_count - a0, pre_count - p0}), 32'h10000);
    // R11: refresh with banks open
    ref_req = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R11 refresh holds ready low", 32'(req_ready), 0);
    p0 = pre_count;
    while (!ref_ack) @(negedge clk);
    chk(cmd == C_REF, "R11 ack in refresh cycle", 32'(cmd), 32'(C_REF));
    chk(pre_count == p0 + 1, "R11 precharge-all before refresh", 32'(pre_count - p0), 1);
    ref_req = 1'b0;
    a0 = act_count;
    do_read(0, 1, 1, 2'b11, 1'b0);
    chk(act_count == a0 + 1, "R11 banks closed by refresh", 32'(act_count - a0), 1);
    // R9/R10: write then miss in same bank, read then write
    do_write(0, 1, 0, 16'h1234, 2'b11, 1'b0);
    do_write(0, 2, 0, 16'h5678, 2'b11, 1'b0);
    do_read(0, 2, 0, 2'b11, 1'b0);
    do_write(0, 2, 1, 16'h9ABC, 2'b11, 1'b0);
    do_read(0, 2, 1, 2'b11, 1'b1);
    repeat (20) @(negedge clk);
    summary();
  end
endmodule